// File: doc/BRIEF.md
# Threshold-Hit Event Buffer with Crossing Timestamp

This block is the digital event logic of one readout chip in a pixel front end. Each channel delivers the outputs of three discriminators set at rising thresholds. On a bunch crossing qualified by the trigger input, the block turns each channel's comparator pattern into a 2-bit energy code. When at least one comparator is high, it stores the codes of all channels in an eight-entry event memory, together with the value of a free-running bunch-crossing counter.

An event counter records how many events were stored. A full flag shows that the memory has no free entry. The trigger is forwarded to the next chip, and a carry pulse tells the next chip that an event was lost here. Stored events leave oldest first through a serial output. When the chip has nothing to shift, its serial output follows the serial input from the previous chip in the chain.

Top module: `hit_event_buffer`

## Requirements
- R1: A channel's comparator bits are hit_i[3c+2:3c], with bit 3c the lowest threshold. The code is 11 if the top comparator is high, else 10 if the middle one is high, else 01 if the lowest is high, else 00.
- R2: A clock edge stores an event only when trig_i is high and at least one comparator bit of any channel is high. Otherwise nothing is stored and evt_cnt_o is unchanged.
- R3: The crossing counter advances by one each clock and wraps from 2^BCID_W-1 to 0. A stored event carries the value the counter held at its capture edge.
- R4: bc_clr_i high at a clock edge sets both the crossing counter and evt_cnt_o to zero at that edge.
- R5: evt_cnt_o increases by one for each event that is actually stored.
- R6: full_o is high while DEPTH events are held. A capture while full is dropped, and evt_cnt_o is unchanged. carry_o is high for exactly the one cycle after the edge of the dropped capture.
- R7: trig_o equals trig_i delayed by one clock.
- R8: When ro_req_i is high at an edge while the shifter is idle and the memory holds data, the oldest event is taken. Its frame is {BCID, code of ch0, ch1, ...}, shifted MSB first on ser_o. ser_valid_o is high for the BCID_W+2*N_CH cycles that start right after that edge.
- R9: Taking an event frees its entry, so full_o is low after that edge. A request while the memory is empty or the shifter is busy is ignored.
- R10: While ser_valid_o is low, ser_o follows ser_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bc_clr_i | input | 1 | Synchronous clear of crossing and event counters |
| trig_i | input | 1 | Trigger qualifying the current crossing |
| hit_i | input | 3*N_CH | Comparator outputs, three per channel |
| ro_req_i | input | 1 | Request to shift out the oldest event |
| ser_i | input | 1 | Serial data from the previous chip |
| trig_o | output | 1 | Trigger forwarded to the next chip |
| carry_o | output | 1 | One-cycle pulse for a capture dropped while full |
| full_o | output | 1 | Event memory holds DEPTH events |
| evt_cnt_o | output | EVT_W | Number of stored events |
| ser_o | output | 1 | Serial frame output, or bypass of ser_i |
| ser_valid_o | output | 1 | ser_o carries frame bits |

## Verification
The bench applies comparator patterns that are not thermometer codes. A design that encoded them by popcount would give 01 where 11 is expected. It fires a ninth capture into a full memory: a design that wraps its write pointer would overwrite the oldest frame, and one that keeps counting would advance evt_cnt_o. Both errors show up when the frames are read out. It captures on the crossing counter's wrap edge and right after a clear, where an off-by-one timestamp appears. It also sends requests while the memory is empty and while the shifter is busy, where a design that did not ignore them would emit extra or corrupt frames.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // highest comparator set decides the code
  function automatic logic [1:0] thr_code(input logic [2:0] cmp);
    if (cmp[2])      thr_code = 2'b11;
    else if (cmp[1]) thr_code = 2'b10;
    else if (cmp[0]) thr_code = 2'b01;
    else             thr_code = 2'b00;
  endfunction
endpackage

// File: rtl/hb_thr_encoder.sv
module hb_thr_encoder #(
  parameter int N_CH = 4
) (
  input  logic [3*N_CH-1:0] hit_i,
  output logic [2*N_CH-1:0] code_o,
  output logic              any_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // ch0 lands in the top bits so it follows the BCID in the frame
    assign code_o[2*(N_CH-1-c) +: 2] = hb_pkg::thr_code(hit_i[3*c +: 3]);
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/hb_event_fifo.sv
module hb_event_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ok, rd_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> (full_o && $stable(wr_ptr_q)));
  // R9
  pop_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && rd_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/hb_serializer.sv
module hb_serializer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         ser_i,
  output logic         ser_o,
  output logic         valid_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shift_q;
  logic [CW-1:0] left_q;

  assign busy_o  = (left_q != '0);
  assign valid_o = busy_o;
  assign ser_o   = busy_o ? shift_q[W-1] : ser_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      left_q  <= '0;
    end else if (load_i && !busy_o) begin
      shift_q <= frame_i;
      left_q  <= CW'(W);
    end else if (busy_o) begin
      shift_q <= {shift_q[W-2:0], 1'b0};
      left_q  <= left_q - 1'b1;
    end
  end

  // R8
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> valid_o);
endmodule

// File: rtl/hit_event_buffer.sv
module hit_event_buffer #(
  parameter int N_CH   = 4,
  parameter int DEPTH  = 8,
  parameter int BCID_W = 8,
  parameter int EVT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bc_clr_i,
  input  logic              trig_i,
  input  logic [3*N_CH-1:0] hit_i,
  input  logic              ro_req_i,
  input  logic              ser_i,
  output logic              trig_o,
  output logic              carry_o,
  output logic              full_o,
  output logic [EVT_W-1:0]  evt_cnt_o,
  output logic              ser_o,
  output logic              ser_valid_o
);
  localparam int CODE_W  = 2 * N_CH;
  localparam int FRAME_W = BCID_W + CODE_W;

  logic [CODE_W-1:0]  codes;
  logic               any_hit, capture, empty, busy, pop;
  logic [FRAME_W-1:0] head;
  logic [BCID_W-1:0]  bcid_q;
  logic [EVT_W-1:0]   evt_q;
  logic               trig_q, carry_q;

  hb_thr_encoder #(.N_CH(N_CH)) u_enc (
    .hit_i (hit_i),
    .code_o(codes),
    .any_o (any_hit)
  );

  assign capture = trig_i && any_hit;
  assign pop     = ro_req_i && !busy && !empty;

  hb_event_fifo #(.DEPTH(DEPTH), .W(FRAME_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (capture),
    .din_i  ({bcid_q, codes}),
    .rd_i   (pop),
    .dout_o (head),
    .full_o (full_o),
    .empty_o(empty)
  );

  hb_serializer #(.W(FRAME_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop),
    .frame_i(head),
    .ser_i  (ser_i),
    .ser_o  (ser_o),
    .valid_o(ser_valid_o),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcid_q  <= '0;
      evt_q   <= '0;
      trig_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      trig_q  <= trig_i;
      carry_q <= capture && full_o;
      if (bc_clr_i) begin
        bcid_q <= '0;
        evt_q  <= '0;
      end else begin
        bcid_q <= bcid_q + 1'b1;
        if (capture && !full_o) evt_q <= evt_q + 1'b1;
      end
    end
  end

  assign trig_o    = trig_q;
  assign carry_o   = carry_q;
  assign evt_cnt_o = evt_q;

  // R6
  carry_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> ($past(full_o) && $past(trig_i)));
  // R5
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !bc_clr_i) |=> $stable(evt_cnt_o));
  // R3
  bcid_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcid_q == '1 && !bc_clr_i) |=> (bcid_q == '0));
endmodule

// File: tb/hit_event_buffer_bench.sv
`timescale 1ns/1ps
module hit_event_buffer_bench;
  localparam int N_CH = 4, DEPTH = 8, BCID_W = 8, EVT_W = 16;
  localparam int FW = BCID_W + 2 * N_CH;

  logic clk = 1'b0, rst_n = 1'b0, bc_clr = 1'b0, trig = 1'b0, ro_req = 1'b0, ser_in = 1'b0;
  logic [3*N_CH-1:0] hit = '0;
  logic trig_o, carry_o, full_o, ser_o, ser_valid_o;
  logic [EVT_W-1:0] evt_cnt_o;

  always #2 clk = ~clk;

  hit_event_buffer #(.N_CH(N_CH), .DEPTH(DEPTH), .BCID_W(BCID_W), .EVT_W(EVT_W)) u_hit_event_buffer (
    .clk_i(clk), .rst_ni(rst_n), .bc_clr_i(bc_clr), .trig_i(trig), .hit_i(hit),
    .ro_req_i(ro_req), .ser_i(ser_in), .trig_o(trig_o), .carry_o(carry_o),
    .full_o(full_o), .evt_cnt_o(evt_cnt_o), .ser_o(ser_o), .ser_valid_o(ser_valid_o));

  int total = 0, bad = 0;
  logic [FW-1:0] exp_q[$];
  logic [BCID_W-1:0] m_bcid = '0;
  logic [EVT_W-1:0]  m_evt = '0;
  int m_occ = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference crossing counter, from R3/R4
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_bcid <= '0;
    else if (bc_clr) m_bcid <= '0;
    else m_bcid <= m_bcid + 1'b1;

  function automatic logic [1:0] code_of(input logic [2:0] c);
    return c[2] ? 2'b11 : c[1] ? 2'b10 : c[0] ? 2'b01 : 2'b00;
  endfunction

  // driver: called at a negedge, leaves trig high until idle()
  task automatic capture(input logic [3*N_CH-1:0] h);
    logic [FW-1:0] f;
    bit stored, dropped;
    f[FW-1 -: BCID_W] = m_bcid;
    for (int c = 0; c < N_CH; c++) f[2*(N_CH-1-c) +: 2] = code_of(h[3*c +: 3]);
    stored  = (h != '0) && (m_occ < DEPTH);
    dropped = (h != '0) && (m_occ >= DEPTH);
    if (stored) begin exp_q.push_back(f); m_occ++; m_evt++; end
    trig = 1'b1; hit = h;
    @(negedge clk);
    chk(trig_o == 1'b1, "R7 trig_o", trig_o, 1);
    chk(carry_o == dropped, dropped ? "R6 carry pulse" : "R6 carry idle", carry_o, dropped);
    chk(evt_cnt_o == m_evt, "R5/R2 evt_cnt", evt_cnt_o, m_evt);
  endtask

  task automatic idle(input int n);
    trig = 1'b0; ro_req = 1'b0; bc_clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_one(input bit expect_frame);
    ro_req = 1'b1;
    @(negedge clk);
    ro_req = 1'b0;
    chk(ser_valid_o == expect_frame, "R8/R9 frame start", ser_valid_o, expect_frame);
    if (expect_frame) m_occ--;
    chk(full_o == (m_occ == DEPTH), "R9 full after pop", full_o, m_occ == DEPTH);
    repeat (FW + 1) @(negedge clk);
  endtask

  // monitor: assemble frames and compare against the scoreboard
  logic [FW-1:0] acc = '0;
  int nb = 0;
  always @(negedge clk) begin
    if (rst_n && ser_valid_o) begin
      acc = {acc[FW-2:0], ser_o};
      nb++;
      if (nb == FW) begin
        nb = 0;
        if (exp_q.size() == 0) chk(0, "R8 unexpected frame", acc, 0);
        else begin
          logic [FW-1:0] e;
          e = exp_q.pop_front();
          chk(acc == e, "R8/R1/R3 frame", acc, e);
        end
      end
    end
  end

  initial begin
    #600000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(full_o == 0 && ser_valid_o == 0 && carry_o == 0 && trig_o == 0, "reset outputs", full_o, 0);
    chk(evt_cnt_o == 0, "reset evt", evt_cnt_o, 0);
    rst_n = 1'b1;
    idle(2);

    // R1: thermometer and non-thermometer patterns
    capture({3'b000, 3'b111, 3'b011, 3'b001});
    capture({3'b010, 3'b100, 3'b101, 3'b110});
    idle(1);
    read_one(1);
    read_one(1);

    // R2: ignored crossings
    hit = 12'hfff; trig = 1'b0;
    repeat (2) @(negedge clk);
    chk(evt_cnt_o == m_evt, "R2 no trig", evt_cnt_o, m_evt);
    capture('0);
    idle(1);
    read_one(0);

    // R6: fill, then drop
    for (int i = 0; i < DEPTH; i++) capture(12'(i + 1));
    idle(1);
    chk(full_o == 1, "R6 full", full_o, 1);
    capture(12'h924);
    idle(1);
    chk(carry_o == 0, "R6 carry one cycle", carry_o, 0);
    // R9: busy request ignored, then drain
    ro_req = 1'b1;
    @(negedge clk);
    m_occ--;
    chk(full_o == 0, "R9 full clears", full_o, 0);
    repeat (3) @(negedge clk);
    ro_req = 1'b0;
    repeat (FW) @(negedge clk);
    for (int i = 1; i < DEPTH; i++) read_one(1);
    chk(exp_q.size() == 0, "R9 drained", exp_q.size(), 0);

    // R4: clear then capture at BCID 0
    bc_clr = 1'b1;
    @(negedge clk);
    bc_clr = 1'b0;
    m_evt = '0;
    chk(evt_cnt_o == 0, "R4 evt clear", evt_cnt_o, 0);
    capture(12'h001);
    idle(1);
    read_one(1);

    // R3: capture on and after the wrap edge
    while (m_bcid != '1) @(negedge clk);
    capture(12'h002);
    capture(12'h004);
    idle(1);
    read_one(1);
    read_one(1);

    // R10: bypass while idle
    ser_in = 1'b1; #1;
    chk(ser_o == 1'b1, "R10 bypass 1", ser_o, 1);
    ser_in = 1'b0; #1;
    chk(ser_o == 1'b0, "R10 bypass 0", ser_o, 0);
    chk(exp_q.size() == 0, "R8 all frames seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule